// File: doc/BRIEF.md
# CPU Halt and Stop Sequencer

This block sits beside the fetch unit of a small 8-bit processor core and decides what happens when the core decodes one of its two sleep instructions. For the light sleep instruction it chooses between three outcomes. The core either parks until an enabled interrupt arrives, or it parks until any request appears. In the third outcome the core does not park at all. Instead, the next opcode fetch is told not to advance the program counter, so that byte is read twice. For the deep sleep instruction it shuts down the core clock and the peripheral clock domain together, and only a reset brings them back.

The interrupt controller supplies two status bits. One says that a request exists whose enable bit is also set. The other says that any request exists. The core's master-enable flag is sampled when the sleep instruction executes. Leaving a park passes through a wake stage of `WAKE_CYCLES` clock cycles. After it the core clock is re-enabled, and a one-cycle resume pulse says whether the interrupt unit should dispatch or whether execution simply continues.

Top module: `cpu_sleep_ctrl`

## Requirements
- R1: In the cycle after reset is applied, `cpu_run`=1, `periph_run`=1, `pc_hold`=0, `resume`=0 and `resume_dispatch`=0.
- R2: `halt_op` with `ime`=1 drops `cpu_run` at the next clock edge. It stays low while `irq_match`=0, even when `irq_any`=1.
- R3: In the dispatch-wait park, the sampled `irq_match`=1 moves the block to a wake stage. `WAKE_CYCLES` edges later, `cpu_run` returns to 1 and `resume`=1 and `resume_dispatch`=1 hold for exactly one cycle.
- R4: `halt_op` with `ime`=0 and `irq_match`=0 parks the core, and any request (`irq_any`=1) wakes it. After the same wake delay, `resume`=1 with `resume_dispatch`=0.
- R5: `halt_op` with `ime`=0 and `irq_match`=1 leaves `cpu_run`=1 and sets `pc_hold`=1 at the next edge.
- R6: `pc_hold` stays 1 until a cycle with `fetch`=1, and it reads 0 after that edge.
- R7: `periph_run` stays 1 through a light park and its wake stage.
- R8: `stop_op` drops both `cpu_run` and `periph_run` at the next edge, and no interrupt status restores them; only `rst` does. When `stop_op` and `halt_op` arrive in the same cycle, `stop_op` takes priority.
- R9: `halt_op` and `stop_op` have no effect while `cpu_run`=0. A parked core still wakes normally and `periph_run` stays 1.
- R10: The wake rule is fixed by `ime` at the time of `halt_op`. A change of `ime` while parked does not change which status bit wakes the core.
- R11: A skip outcome in the same cycle as a `fetch` leaves `pc_hold`=1, because setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_op | input | 1 | Light sleep instruction executes this cycle |
| stop_op | input | 1 | Deep sleep instruction executes this cycle |
| ime | input | 1 | Master interrupt enable flag of the core |
| irq_match | input | 1 | A request is pending and its enable bit is set |
| irq_any | input | 1 | At least one request bit is set |
| fetch | input | 1 | An opcode fetch takes place this cycle |
| cpu_run | output | 1 | Core clock enable (0 while parked or stopped) |
| periph_run | output | 1 | Oscillator and display clock enable (0 only when stopped) |
| pc_hold | output | 1 | Suppress the program counter increment on the next fetch |
| resume | output | 1 | One-cycle pulse when the core clock comes back |
| resume_dispatch | output | 1 | With `resume`: the interrupt unit should dispatch |

## Verification
Every output is a register, so a strobe sampled at one edge shows up at the very next edge. Examples are the loss of `cpu_run` after `halt_op` or `stop_op`, and the setting or clearing of `pc_hold`. A wake condition takes `WAKE_CYCLES`+1 edges to reach `resume` and `cpu_run`. The bench drives inputs just after a falling edge and samples just before the next one. A behavioural model advances on each rising edge and is compared with all five outputs at every falling edge. The scenario checks count edges to the cycle where each result is due: one edge for entry and skip, two for wake with the default delay, and a further edge for the pulse to end.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  // Sequencer state
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PARK = 2'd1,
    ST_WAKE = 2'd2,
    ST_DEAD = 2'd3
  } sleep_st_e;

  // Outcome of the sleep strobes in the current cycle
  typedef enum logic [2:0] {
    OC_NONE     = 3'd0,
    OC_PARK_IRQ = 3'd1,
    OC_PARK_ANY = 3'd2,
    OC_SKIP     = 3'd3,
    OC_DEAD     = 3'd4
  } sleep_oc_e;

endpackage

// File: rtl/sleep_outcome.sv
module sleep_outcome
  import sleep_pkg::*;
(
  input  logic      running,
  input  logic      halt_op,
  input  logic      stop_op,
  input  logic      ime,
  input  logic      irq_match,
  output sleep_oc_e outcome
);

  always_comb begin
    outcome = OC_NONE;
    if (running) begin
      if (stop_op) begin
        outcome = OC_DEAD;
      end else if (halt_op) begin
        if (ime)            outcome = OC_PARK_IRQ;
        else if (irq_match) outcome = OC_SKIP;
        else                outcome = OC_PARK_ANY;
      end
    end
  end

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int WAKE_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  sleep_oc_e outcome,
  input  logic      irq_match,
  input  logic      irq_any,
  output sleep_st_e st_q,
  output logic      wait_match_q,
  output logic      cpu_run_q,
  output logic      periph_run_q,
  output logic      resume_q,
  output logic      resume_dispatch_q
);

  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES + 1) : 1;

  sleep_st_e st_d;
  logic      wait_match_d;
  logic      wake_hit;
  logic      wake_done;
  logic      leaving;

  assign wake_hit = wait_match_q ? irq_match : irq_any;

  generate
    if (WAKE_CYCLES <= 1) begin : g_nocnt
      assign wake_done = 1'b1;
    end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (st_q == ST_PARK) begin
          cnt_q <= CW'(WAKE_CYCLES - 1);
        end else if (st_q == ST_WAKE && cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      assign wake_done = (cnt_q == '0);
    end
  endgenerate

  always_comb begin
    st_d         = st_q;
    wait_match_d = wait_match_q;
    unique case (st_q)
      ST_RUN: begin
        unique case (outcome)
          OC_DEAD:     st_d = ST_DEAD;
          OC_PARK_IRQ: begin st_d = ST_PARK; wait_match_d = 1'b1; end
          OC_PARK_ANY: begin st_d = ST_PARK; wait_match_d = 1'b0; end
          default:     st_d = ST_RUN;
        endcase
      end
      ST_PARK: if (wake_hit)  st_d = ST_WAKE;
      ST_WAKE: if (wake_done) st_d = ST_RUN;
      default: st_d = ST_DEAD;
    endcase
  end

  assign leaving = (st_q == ST_WAKE) && (st_d == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q              <= ST_RUN;
      wait_match_q      <= 1'b0;
      cpu_run_q         <= 1'b1;
      periph_run_q      <= 1'b1;
      resume_q          <= 1'b0;
      resume_dispatch_q <= 1'b0;
    end else begin
      st_q              <= st_d;
      wait_match_q      <= wait_match_d;
      cpu_run_q         <= (st_d == ST_RUN);
      periph_run_q      <= (st_d != ST_DEAD);
      resume_q          <= leaving;
      resume_dispatch_q <= leaving && wait_match_q;
    end
  end

endmodule

// File: rtl/pc_skip_flag.sv
module pc_skip_flag (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic fetch,
  output logic hold_q
);

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= 1'b0;
    else if (arm)   hold_q <= 1'b1;
    else if (fetch) hold_q <= 1'b0;
  end

endmodule

// File: rtl/cpu_sleep_ctrl.sv
module cpu_sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int WAKE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_op,
  input  logic stop_op,
  input  logic ime,
  input  logic irq_match,
  input  logic irq_any,
  input  logic fetch,
  output logic cpu_run,
  output logic periph_run,
  output logic pc_hold,
  output logic resume,
  output logic resume_dispatch
);

  sleep_oc_e outcome;
  sleep_st_e seq_st;
  logic      seq_wait_match;

  sleep_outcome u_outcome (
    .running   (cpu_run),
    .halt_op   (halt_op),
    .stop_op   (stop_op),
    .ime       (ime),
    .irq_match (irq_match),
    .outcome   (outcome)
  );

  sleep_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk               (clk),
    .rst               (rst),
    .outcome           (outcome),
    .irq_match         (irq_match),
    .irq_any           (irq_any),
    .st_q              (seq_st),
    .wait_match_q      (seq_wait_match),
    .cpu_run_q         (cpu_run),
    .periph_run_q      (periph_run),
    .resume_q          (resume),
    .resume_dispatch_q (resume_dispatch)
  );

  pc_skip_flag u_skip (
    .clk    (clk),
    .rst    (rst),
    .arm    (outcome == OC_SKIP),
    .fetch  (fetch),
    .hold_q (pc_hold)
  );

endmodule

// File: rtl/cpu_sleep_ctrl_chk.sv
module cpu_sleep_ctrl_chk
  import sleep_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      halt_op,
  input logic      stop_op,
  input logic      ime,
  input logic      irq_match,
  input logic      fetch,
  input logic      cpu_run,
  input logic      periph_run,
  input logic      pc_hold,
  input logic      resume,
  input logic      resume_dispatch,
  input sleep_st_e seq_st,
  input logic      seq_wait_match
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cpu_run && periph_run && !pc_hold && !resume && !resume_dispatch));

  assert_park_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (seq_st == ST_PARK && seq_wait_match && !irq_match) |=> !cpu_run);

  assert_resume_once_R3: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);

  assert_resume_running_R3: assert property (@(posedge clk) disable iff (rst)
    resume |-> cpu_run);

  assert_dispatch_only_with_resume_R4: assert property (@(posedge clk) disable iff (rst)
    resume_dispatch |-> resume);

  assert_skip_sets_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_run && halt_op && !stop_op && !ime && irq_match) |=> (cpu_run && pc_hold));

  assert_fetch_clears_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_hold && fetch && !(cpu_run && halt_op)) |=> !pc_hold);

  assert_periph_in_park_R7: assert property (@(posedge clk) disable iff (rst)
    (seq_st == ST_PARK) |-> periph_run);

  assert_stop_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !periph_run |=> (!periph_run && !cpu_run));

  assert_strobes_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (!cpu_run && periph_run) |=> periph_run);

endmodule

bind cpu_sleep_ctrl cpu_sleep_ctrl_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .halt_op         (halt_op),
  .stop_op         (stop_op),
  .ime             (ime),
  .irq_match       (irq_match),
  .fetch           (fetch),
  .cpu_run         (cpu_run),
  .periph_run      (periph_run),
  .pc_hold         (pc_hold),
  .resume          (resume),
  .resume_dispatch (resume_dispatch),
  .seq_st          (seq_st),
  .seq_wait_match  (seq_wait_match)
);

// File: tb/sim_cpu_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_sleep_ctrl;

  localparam int WAKE = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_op = 1'b0, stop_op = 1'b0, ime = 1'b0;
  logic irq_match = 1'b0, irq_any = 1'b0, fetch = 1'b0;
  logic cpu_run, periph_run, pc_hold, resume, resume_dispatch;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cpu_sleep_ctrl #(.WAKE_CYCLES(WAKE)) u0 (
    .clk(clk), .rst(rst), .halt_op(halt_op), .stop_op(stop_op), .ime(ime),
    .irq_match(irq_match), .irq_any(irq_any), .fetch(fetch),
    .cpu_run(cpu_run), .periph_run(periph_run), .pc_hold(pc_hold),
    .resume(resume), .resume_dispatch(resume_dispatch)
  );

  // Reference model: 0 running, 1 parked, 2 waking, 3 stopped
  int m_st = 0;
  int m_cnt = 0;
  bit m_wm = 0, m_hold = 0, m_res = 0, m_disp = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_cnt <= 0; m_wm <= 0; m_hold <= 0; m_res <= 0; m_disp <= 0;
    end else begin
      m_res  <= 0;
      m_disp <= 0;
      if (fetch) m_hold <= 0;
      case (m_st)
        0: begin
          if (stop_op) m_st <= 3;
          else if (halt_op) begin
            if (ime) begin m_st <= 1; m_wm <= 1; end
            else if (!irq_match) begin m_st <= 1; m_wm <= 0; end
            else m_hold <= 1;
          end
        end
        1: if (m_wm ? irq_match : irq_any) begin m_st <= 2; m_cnt <= WAKE - 1; end
        2: begin
          if (m_cnt == 0) begin m_st <= 0; m_res <= 1; m_disp <= m_wm; end
          else m_cnt <= m_cnt - 1;
        end
        default: m_st <= 3;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2", "cpu_run(model)", cpu_run, m_st == 0);
      chk("R8", "periph_run(model)", periph_run, m_st != 3);
      chk("R6", "pc_hold(model)", pc_hold, m_hold);
      chk("R3", "resume(model)", resume, m_res);
      chk("R4", "resume_dispatch(model)", resume_dispatch, m_disp);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_halt();
    halt_op = 1'b1;
    @(negedge clk);
    halt_op = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cpu_run", cpu_run, 1'b1);
    chk("R1", "periph_run", periph_run, 1'b1);
    chk("R1", "pc_hold", pc_hold, 1'b0);
    chk("R1", "resume", resume, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // R2, R3, R7: park waiting for an enabled interrupt
    ime = 1'b1;
    pulse_halt();
    chk("R2", "cpu_run after halt", cpu_run, 1'b0);
    irq_any = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", "cpu_run with unenabled request", cpu_run, 1'b0);
    chk("R7", "periph_run while parked", periph_run, 1'b1);
    irq_match = 1'b1;
    @(negedge clk);
    chk("R3", "cpu_run in wake stage", cpu_run, 1'b0);
    chk("R7", "periph_run in wake stage", periph_run, 1'b1);
    @(negedge clk);
    chk("R3", "cpu_run back", cpu_run, 1'b1);
    chk("R3", "resume pulse", resume, 1'b1);
    chk("R3", "resume_dispatch", resume_dispatch, 1'b1);
    irq_match = 1'b0; irq_any = 1'b0;
    @(negedge clk);
    chk("R3", "resume ends", resume, 1'b0);

    // R4, R10: park waiting for any request, ime changes meanwhile
    ime = 1'b0;
    pulse_halt();
    chk("R4", "cpu_run after halt", cpu_run, 1'b0);
    ime = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "cpu_run after ime change", cpu_run, 1'b0);
    irq_any = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "woken by any request", cpu_run, 1'b1);
    chk("R4", "resume pulse", resume, 1'b1);
    chk("R4", "resume_dispatch", resume_dispatch, 1'b0);
    irq_any = 1'b0; ime = 1'b0;
    @(negedge clk);

    // R5, R6: skipped park, repeated fetch
    irq_any = 1'b1; irq_match = 1'b1;
    pulse_halt();
    chk("R5", "cpu_run stays", cpu_run, 1'b1);
    chk("R5", "pc_hold set", pc_hold, 1'b1);
    repeat (2) @(negedge clk);
    chk("R6", "pc_hold waits for fetch", pc_hold, 1'b1);
    fetch = 1'b1;
    @(negedge clk);
    fetch = 1'b0;
    chk("R6", "pc_hold cleared by fetch", pc_hold, 1'b0);

    // R11: skip and fetch in the same cycle
    pulse_halt();
    chk("R11", "pc_hold set again", pc_hold, 1'b1);
    halt_op = 1'b1; fetch = 1'b1;
    @(negedge clk);
    halt_op = 1'b0; fetch = 1'b0;
    chk("R11", "set wins over fetch", pc_hold, 1'b1);
    fetch = 1'b1;
    @(negedge clk);
    fetch = 1'b0;
    chk("R11", "later fetch clears", pc_hold, 1'b0);
    irq_any = 1'b0; irq_match = 1'b0;

    // R9: strobes while parked
    ime = 1'b1;
    pulse_halt();
    stop_op = 1'b1;
    @(negedge clk);
    stop_op = 1'b0;
    pulse_halt();
    chk("R9", "periph_run after ignored stop", periph_run, 1'b1);
    chk("R9", "cpu_run still parked", cpu_run, 1'b0);
    irq_any = 1'b1; irq_match = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "normal wake", cpu_run, 1'b1);
    irq_any = 1'b0; irq_match = 1'b0;
    @(negedge clk);

    // R8: stop with priority over halt, sticky until reset
    halt_op = 1'b1; stop_op = 1'b1;
    @(negedge clk);
    halt_op = 1'b0; stop_op = 1'b0;
    chk("R8", "cpu_run stopped", cpu_run, 1'b0);
    chk("R8", "periph_run stopped", periph_run, 1'b0);
    irq_any = 1'b1; irq_match = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8", "cpu_run ignores interrupts", cpu_run, 1'b0);
    chk("R8", "periph_run ignores interrupts", periph_run, 1'b0);
    irq_any = 1'b0; irq_match = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "cpu_run after reset", cpu_run, 1'b1);
    chk("R1", "periph_run after reset", periph_run, 1'b1);
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule